// File: doc/BRIEF.md
# Network Function Configuration Register Slice

This block holds a handful of the identification, cache line size and status fields of a Type 0 configuration header belonging to a network controller function. A bus front end, outside this block, decodes configuration cycles and presents them on a plain dword-addressed port: a write strobe, byte enables and write data, plus a dword address from which the read data is formed combinationally. Strap inputs loaded from the serial configuration memory pick the silicon stepping, patch the low revision bits and advertise the power-management capability. The capability pointer value itself also arrives as an input.

The cache line size field keeps only the two sizes the function's DMA engine can use, 8 and 16 dwords. Any other value written to it reads back as zero, and the memory-write-and-invalidate permission it drives to the DMA engine is withdrawn. A sticky master data parity status bit records a parity error that this agent saw while it was bus master with parity response enabled. Software clears that bit by writing a one to it.

Top module: `netfn_cfg_regs`

## Requirements
- R1: Dword 2 bits 7:0 (revision) read 0x08 when `step_sel` is 0 and 0x09 when it is 1, with no override active.
- R2: While `ee_rev_ovr` is 1, revision bits 2:0 read `ee_rev_lo` and bits 7:3 keep the stepping default.
- R3: Dword 2 bits 31:8 always read 0x020000, meaning base class 0x02, subclass 0x00 and interface 0x00. Writes to dword 2 change nothing.
- R4: A write to dword 3 with byte enable 0 set and data bits 7:0 equal to 8 or 16 makes dword 3 bits 7:0 and `cls_active` equal that value, and sets `mwi_ok` to 1, from the next cycle.
- R5: A write to dword 3 with byte enable 0 set and any other bits 7:0 value makes dword 3 read 0, `cls_active` 0 and `mwi_ok` 0 from the next cycle.
- R6: A write to dword 3 with byte enable 0 clear leaves the cache line size and `mwi_ok` unchanged.
- R7: After reset the cache line size reads 0, `mwi_ok` is 0 and the parity status bit (dword 1 bit 24) is 0.
- R8: The parity status bit is set in the cycle after `perr_seen`, `bus_master_act` and `cmd_perr_resp` are all 1 together. It is not set if any of the three is 0.
- R9: The parity status bit stays set until a write to dword 1 with byte enable 3 set and data bit 24 equal to 1. Writing 0 there, or writing with byte enable 3 clear, has no effect. A set condition in the same cycle as a clear keeps the bit at 1.
- R10: Dword 1 bit 23 (fast back-to-back capable) always reads 1. Bit 20 (capabilities list) reads `ee_pm_en`. Bits 19:16 read 0000b, and writes to dword 1 leave bits 23:16 unchanged.
- R11: Dword 13 bits 7:0 read `cap_ptr_in` when `ee_pm_en` is 1 and 0 otherwise.
- R12: Dword 0 and any dword address other than 1, 2, 3 and 13 read as all zeroes. The same holds for every field of dwords 1, 2, 3 and 13 not named above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 6 | Dword address of the configuration access |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| step_sel | input | 1 | Stepping select: 0 gives revision 0x08, 1 gives 0x09 |
| ee_rev_ovr | input | 1 | Revision override valid strap |
| ee_rev_lo | input | 3 | Replacement for revision bits 2:0 |
| ee_pm_en | input | 1 | Power-management capability enable strap |
| cap_ptr_in | input | 8 | Capability pointer value |
| perr_seen | input | 1 | Parity error driven or observed on the bus |
| bus_master_act | input | 1 | This agent is master of the current transaction |
| cmd_perr_resp | input | 1 | Parity error response enable from the command register |
| mwi_ok | output | 1 | Memory-write-and-invalidate permitted |
| cls_active | output | 8 | Cache line size in use, in dwords (0, 8 or 16) |

## Verification
The cache line size is the one piece of state that reaches the ports on more than one path: read data, `cls_active` and `mwi_ok` all come from it. A mis-accepted or mis-rejected write therefore shows as a wrong value on all three one cycle after the write strobe, and the permission flag goes wrong at the same moment as the readback. A parity status bit stuck in the wrong state appears at dword 1 bit 24 in the cycle after the event, or after the clearing write, that should have changed it. A lost set, a missed clear and a wrong set-versus-clear priority are each seen by a single readback. The identification and status constants have no state, so a wrong strap mapping is wrong in the very cycle the straps or the address change.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
  localparam int DW_W        = 32;
  localparam int ADDR_W      = 6;
  localparam int BE_W        = DW_W / 8;

  localparam logic [ADDR_W-1:0] DWA_CMDSTAT = 6'd1;
  localparam logic [ADDR_W-1:0] DWA_IDCLASS = 6'd2;
  localparam logic [ADDR_W-1:0] DWA_LINE    = 6'd3;
  localparam logic [ADDR_W-1:0] DWA_CAPPTR  = 6'd13;

  localparam logic [7:0]  REV_BASE_A   = 8'h08;
  localparam logic [7:0]  REV_BASE_B   = 8'h09;
  localparam logic [23:0] CLASS_NETETH = 24'h020000;

  localparam logic [7:0] LINE_SMALL = 8'd8;
  localparam logic [7:0] LINE_LARGE = 8'd16;

  // Bit of the master data parity flag within the 16-bit status half
  localparam int ST_PERR_BIT = 8;
  // Same bit seen in the full dword
  localparam int DW_PERR_BIT = 16 + ST_PERR_BIT;

  function automatic logic [7:0] rev_value(input logic step, input logic ovr,
                                           input logic [2:0] lo);
    logic [7:0] base;
    base = step ? REV_BASE_B : REV_BASE_A;
    return ovr ? {base[7:3], lo} : base;
  endfunction

  function automatic logic line_legal(input logic [7:0] v);
    return (v == LINE_SMALL) || (v == LINE_LARGE);
  endfunction

  function automatic logic [15:0] status_word(input logic perr, input logic cap);
    // 15:9 zero, 8 parity flag, 7 fast b2b, 6:5 zero, 4 cap list, 3:0 zero
    return {7'b0, perr, 1'b1, 2'b00, cap, 4'b0000};
  endfunction
endpackage

// File: rtl/cfgr_ident.sv
module cfgr_ident
  import cfgr_pkg::*;
(
  input  logic            step_sel,
  input  logic            ee_rev_ovr,
  input  logic [2:0]      ee_rev_lo,
  output logic [DW_W-1:0] id_dword
);
  logic [7:0] rev_byte;

  always_comb begin
    rev_byte = rev_value(step_sel, ee_rev_ovr, ee_rev_lo);
    id_dword = {CLASS_NETETH, rev_byte};
  end
endmodule

// File: rtl/cfgr_linesize.sv
module cfgr_linesize
  import cfgr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  output logic [7:0] line_q,
  output logic       mwi_ok,
  output logic       bad_wr_evt
);
  logic       good;
  logic [7:0] line_d;

  always_comb begin
    good       = line_legal(wr_byte);
    bad_wr_evt = wr_stb && !good;
    line_d     = line_q;
    if (wr_stb) line_d = good ? wr_byte : 8'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 8'd0;
      mwi_ok <= 1'b0;
    end else begin
      line_q <= line_d;
      mwi_ok <= (line_d != 8'd0);
    end
  end
endmodule

// File: rtl/cfgr_status.sv
module cfgr_status
  import cfgr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        perr_seen,
  input  logic        bus_master_act,
  input  logic        cmd_perr_resp,
  input  logic        clr_stb,
  input  logic        ee_pm_en,
  output logic        perr_q,
  output logic        set_evt,
  output logic [15:0] status_hw
);
  always_comb begin
    set_evt   = perr_seen && bus_master_act && cmd_perr_resp;
    status_hw = status_word(perr_q, ee_pm_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       perr_q <= 1'b0;
    else if (set_evt) perr_q <= 1'b1;   // set wins over a same-cycle clear
    else if (clr_stb) perr_q <= 1'b0;
  end
endmodule

// File: rtl/netfn_cfg_regs.sv
module netfn_cfg_regs
  import cfgr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [BE_W-1:0]   cfg_be,
  input  logic [DW_W-1:0]   cfg_wdata,
  output logic [DW_W-1:0]   cfg_rdata,
  input  logic              step_sel,
  input  logic              ee_rev_ovr,
  input  logic [2:0]        ee_rev_lo,
  input  logic              ee_pm_en,
  input  logic [7:0]        cap_ptr_in,
  input  logic              perr_seen,
  input  logic              bus_master_act,
  input  logic              cmd_perr_resp,
  output logic              mwi_ok,
  output logic [7:0]        cls_active
);
  // Decoded write events, named for the checker
  logic        cls_wr_stb;
  logic        perr_clr_evt;
  logic        perr_set_evt;
  logic        cls_bad_evt;
  logic        perr_sticky;
  logic [DW_W-1:0] id_dword;
  logic [15:0] status_hw;

  assign cls_wr_stb   = cfg_wr && (cfg_addr == DWA_LINE) && cfg_be[0];
  assign perr_clr_evt = cfg_wr && (cfg_addr == DWA_CMDSTAT) && cfg_be[3]
                        && cfg_wdata[DW_PERR_BIT];

  cfgr_ident u_ident (
    .step_sel   (step_sel),
    .ee_rev_ovr (ee_rev_ovr),
    .ee_rev_lo  (ee_rev_lo),
    .id_dword   (id_dword)
  );

  cfgr_linesize u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (cls_wr_stb),
    .wr_byte    (cfg_wdata[7:0]),
    .line_q     (cls_active),
    .mwi_ok     (mwi_ok),
    .bad_wr_evt (cls_bad_evt)
  );

  cfgr_status u_stat (
    .clk            (clk),
    .rst_n          (rst_n),
    .perr_seen      (perr_seen),
    .bus_master_act (bus_master_act),
    .cmd_perr_resp  (cmd_perr_resp),
    .clr_stb        (perr_clr_evt),
    .ee_pm_en       (ee_pm_en),
    .perr_q         (perr_sticky),
    .set_evt        (perr_set_evt),
    .status_hw      (status_hw)
  );

  always_comb begin
    unique case (cfg_addr)
      DWA_CMDSTAT: cfg_rdata = {status_hw, 16'h0000};
      DWA_IDCLASS: cfg_rdata = id_dword;
      DWA_LINE:    cfg_rdata = {24'h0, cls_active};
      DWA_CAPPTR:  cfg_rdata = {24'h0, ee_pm_en ? cap_ptr_in : 8'h00};
      default:     cfg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31:25], cfg_wdata[23:8], cfg_be[2:1], cls_bad_evt};
endmodule

// File: rtl/netfn_cfg_chk.sv
module netfn_cfg_chk
  import cfgr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_wr,
  input logic [BE_W-1:0]   cfg_be,
  input logic [DW_W-1:0]   cfg_wdata,
  input logic [DW_W-1:0]   cfg_rdata,
  input logic              perr_seen,
  input logic              bus_master_act,
  input logic              cmd_perr_resp,
  input logic              mwi_ok,
  input logic [7:0]        cls_active,
  input logic              perr_sticky,
  input logic              perr_clr_evt
);
  logic set_cond;
  logic cls_hit;
  assign set_cond = perr_seen && bus_master_act && cmd_perr_resp;
  assign cls_hit  = cfg_wr && (cfg_addr == DWA_LINE);

  // R4: only the two legal sizes or zero can ever be in use
  a_r4_size_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_active == 8'd0) || (cls_active == 8'd8) || (cls_active == 8'd16));

  // R4: a legal size write is taken and permits MWI
  a_r4_legal_taken: assert property (@(posedge clk) disable iff (!rst_n)
    cls_hit && cfg_be[0] && line_legal(cfg_wdata[7:0])
    |=> (cls_active == $past(cfg_wdata[7:0])) && mwi_ok);

  // R5: an illegal size write zeroes the size and blocks MWI
  a_r5_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cls_hit && cfg_be[0] && !line_legal(cfg_wdata[7:0])
    |=> (cls_active == 8'd0) && !mwi_ok);

  // R6: lane 0 disabled leaves the size alone
  a_r6_lane_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cls_hit && !cfg_be[0] |=> $stable(cls_active) && $stable(mwi_ok));

  // R8: the three conditions together set the parity flag
  a_r8_perr_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_cond |=> perr_sticky);

  // R9: sticky until a clearing write
  a_r9_perr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    perr_sticky && !perr_clr_evt |=> perr_sticky);

  // R9: a clear with no concurrent set drops the flag
  a_r9_perr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    perr_clr_evt && !set_cond |=> !perr_sticky);

  // R10: fixed status bits
  a_r10_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == DWA_CMDSTAT) |-> cfg_rdata[23] && (cfg_rdata[19:16] == 4'h0));

  // R12: unmapped addresses read zero
  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != DWA_CMDSTAT) && (cfg_addr != DWA_IDCLASS) &&
    (cfg_addr != DWA_LINE) && (cfg_addr != DWA_CAPPTR) |-> cfg_rdata == '0);
endmodule

bind netfn_cfg_regs netfn_cfg_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_addr       (cfg_addr),
  .cfg_wr         (cfg_wr),
  .cfg_be         (cfg_be),
  .cfg_wdata      (cfg_wdata),
  .cfg_rdata      (cfg_rdata),
  .perr_seen      (perr_seen),
  .bus_master_act (bus_master_act),
  .cmd_perr_resp  (cmd_perr_resp),
  .mwi_ok         (mwi_ok),
  .cls_active     (cls_active),
  .perr_sticky    (perr_sticky),
  .perr_clr_evt   (perr_clr_evt)
);

// File: tb/netfn_cfg_regs_tb.sv
module netfn_cfg_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        step_sel = 1'b0, ee_rev_ovr = 1'b0, ee_pm_en = 1'b0;
  logic [2:0]  ee_rev_lo = 3'b0;
  logic [7:0]  cap_ptr_in = 8'h5C;
  logic        perr_seen = 1'b0, bus_master_act = 1'b0, cmd_perr_resp = 1'b0;
  logic        mwi_ok;
  logic [7:0]  cls_active;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  netfn_cfg_regs u_dut (.*);

  typedef struct packed {
    logic        is_wr;
    logic [5:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 6'd2,  4'h0, 32'h0,        32'h02000008, 8'd1},  // R1 R3
    '{1'b1, 6'd2,  4'hF, 32'hFFFFFFFF, 32'h0,        8'd3},
    '{1'b0, 6'd2,  4'h0, 32'h0,        32'h02000008, 8'd3},  // R3 write ignored
    '{1'b1, 6'd3,  4'h1, 32'h00000010, 32'h0,        8'd4},
    '{1'b0, 6'd3,  4'h0, 32'h0,        32'h00000010, 8'd4},  // R4 size 16
    '{1'b1, 6'd3,  4'h1, 32'hAB000008, 32'h0,        8'd4},
    '{1'b0, 6'd3,  4'h0, 32'h0,        32'h00000008, 8'd4},  // R4 size 8
    '{1'b1, 6'd3,  4'h1, 32'h0000000C, 32'h0,        8'd5},
    '{1'b0, 6'd3,  4'h0, 32'h0,        32'h00000000, 8'd5},  // R5 12 rejected
    '{1'b1, 6'd3,  4'h1, 32'h00000010, 32'h0,        8'd6},
    '{1'b1, 6'd3,  4'hE, 32'h0000000C, 32'h0,        8'd6},
    '{1'b0, 6'd3,  4'h0, 32'h0,        32'h00000010, 8'd6},  // R6 lane 0 off
    '{1'b1, 6'd3,  4'h1, 32'h00000020, 32'h0,        8'd5},
    '{1'b0, 6'd3,  4'h0, 32'h0,        32'h00000000, 8'd5},  // R5 32 rejected
    '{1'b1, 6'd3,  4'h1, 32'h00000018, 32'h0,        8'd5},
    '{1'b0, 6'd3,  4'h0, 32'h0,        32'h00000000, 8'd5},  // R5 24 rejected
    '{1'b0, 6'd1,  4'h0, 32'h0,        32'h00800000, 8'd10}, // R10
    '{1'b1, 6'd1,  4'hF, 32'hFEFFFFFF, 32'h0,        8'd10},
    '{1'b0, 6'd1,  4'h0, 32'h0,        32'h00800000, 8'd10}, // R10 writes ignored
    '{1'b0, 6'd13, 4'h0, 32'h0,        32'h00000000, 8'd11}, // R11 pm off
    '{1'b0, 6'd0,  4'h0, 32'h0,        32'h00000000, 8'd12}, // R12
    '{1'b1, 6'd5,  4'hF, 32'h12345678, 32'h0,        8'd12},
    '{1'b0, 6'd5,  4'h0, 32'h0,        32'h00000000, 8'd12}  // R12
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Inputs change at the falling edge; the write lands at the next rising edge
  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic pulse_perr(input logic s, input logic m, input logic r);
    @(negedge clk);
    perr_seen = s; bus_master_act = m; cmd_perr_resp = r;
    @(negedge clk);
    perr_seen = 1'b0; bus_master_act = 1'b0; cmd_perr_resp = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    rd(6'd3, d);      chk("R7 line size after reset", d, 32'h0);
    chk("R7 mwi_ok after reset", {31'b0, mwi_ok}, 32'h0);
    chk("R7 cls_active after reset", {24'b0, cls_active}, 32'h0);
    rd(6'd1, d);      chk("R7 parity flag after reset", {31'b0, d[24]}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].is_wr) wr(TBL[i].addr, TBL[i].be, TBL[i].data);
      else begin
        rd(TBL[i].addr, d);
        checks++;
        if (d !== TBL[i].exp) begin
          errors++;
          $display("FAIL R%0d table row %0d: got %h expected %h", TBL[i].req, i, d, TBL[i].exp);
        end
      end
    end

    // R4 / R5 on the side outputs
    wr(6'd3, 4'h1, 32'h10);
    #1 chk("R4 cls_active 16", {24'b0, cls_active}, 32'd16);
    chk("R4 mwi_ok 16", {31'b0, mwi_ok}, 32'd1);
    wr(6'd3, 4'h1, 32'h07);
    #1 chk("R5 cls_active zero", {24'b0, cls_active}, 32'd0);
    chk("R5 mwi_ok off", {31'b0, mwi_ok}, 32'd0);
    wr(6'd3, 4'h1, 32'h08);
    wr(6'd3, 4'h0, 32'h55);
    #1 chk("R6 no lanes keeps size", {24'b0, cls_active}, 32'd8);
    chk("R6 no lanes keeps mwi", {31'b0, mwi_ok}, 32'd1);

    // R1 / R2 revision straps
    step_sel = 1'b1;
    rd(6'd2, d);      chk("R1 revision step B", d, 32'h02000009);
    ee_rev_ovr = 1'b1; ee_rev_lo = 3'b101;
    rd(6'd2, d);      chk("R2 override on step B", d, 32'h0200000D);
    step_sel = 1'b0; ee_rev_lo = 3'b111;
    rd(6'd2, d);      chk("R2 override on step A", d, 32'h0200000F);
    ee_rev_ovr = 1'b0;
    rd(6'd2, d);      chk("R1 override released", d, 32'h02000008);

    // R10 / R11 power-management strap
    ee_pm_en = 1'b1;
    rd(6'd1, d);      chk("R10 capabilities bit", d, 32'h00900000);
    rd(6'd13, d);     chk("R11 pointer shown", d, 32'h0000005C);
    ee_pm_en = 1'b0;

    // R8 partial conditions do not set
    pulse_perr(1'b1, 1'b1, 1'b0);
    pulse_perr(1'b1, 1'b0, 1'b1);
    pulse_perr(1'b0, 1'b1, 1'b1);
    rd(6'd1, d);      chk("R8 partial conditions", {31'b0, d[24]}, 32'h0);
    pulse_perr(1'b1, 1'b1, 1'b1);
    rd(6'd1, d);      chk("R8 all conditions set", {31'b0, d[24]}, 32'h1);
    repeat (4) @(negedge clk);
    rd(6'd1, d);      chk("R9 flag held", {31'b0, d[24]}, 32'h1);
    wr(6'd1, 4'hF, 32'hFEFFFFFF);
    rd(6'd1, d);      chk("R9 write zero no effect", {31'b0, d[24]}, 32'h1);
    wr(6'd1, 4'h7, 32'h01000000);
    rd(6'd1, d);      chk("R9 lane 3 off no effect", {31'b0, d[24]}, 32'h1);
    wr(6'd1, 4'h8, 32'h01000000);
    rd(6'd1, d);      chk("R9 write one clears", {31'b0, d[24]}, 32'h0);

    // R9 set and clear in the same cycle: set wins
    pulse_perr(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    cfg_addr = 6'd1; cfg_be = 4'h8; cfg_wdata = 32'h01000000; cfg_wr = 1'b1;
    perr_seen = 1'b1; bus_master_act = 1'b1; cmd_perr_resp = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
    perr_seen = 1'b0; bus_master_act = 1'b0; cmd_perr_resp = 1'b0;
    rd(6'd1, d);      chk("R9 set wins over clear", {31'b0, d[24]}, 32'h1);

    // R7 reset again clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(6'd1, d);      chk("R7 reset clears parity flag", {31'b0, d[24]}, 32'h0);
    #1 chk("R7 reset clears size", {24'b0, cls_active}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule